// File: doc/BRIEF.md
# Memory Cluster Local Register Manager

This block sits inside the memory cluster of a clustered vector coprocessor. It owns a small pool of local vector registers, called slots, that stand between the memory system and the cluster interconnect, so that execution clusters never wait on memory latency. Every architectural load is split into a memory read that fills a local slot and a later move-out that streams the slot onto the interconnect. Every architectural store is split into a move-in that fills a slot from the interconnect and a later memory write from that slot. A combined store-and-free operation writes a slot to memory and releases it in the same operation.

Micro-operations arrive one at a time on a valid/ready issue port. Operations that need a new slot (load, move-in) take the lowest-numbered free slot and report its number back to the issuer, which uses it to name the slot in later move-out and store operations. When every slot is taken, the issue port stalls such operations. Memory reads are sent as unit-stride element requests. Responses come back after any latency, in request order, and fill the slot element by element. A move-out or store of a slot whose load is still in flight proceeds element by element as each element arrives.

The memory request channel, the transfer input and the transfer output are valid/ready streams. A sender holds valid and its payload unchanged until ready is seen high at a clock edge. Memory responses have no ready: the block accepts one element per cycle whenever response valid is high.

Top module: `mcr_decouple_mgr`

## Requirements
- R1: After reset the block is idle: iss_ready is 1, and mem_req_valid, xout_valid, xin_ready and alloc_valid are 0.
- R2: A load (iss_op 0) or a move-in (iss_op 1) that is accepted takes the lowest-numbered free slot. alloc_valid is 1 for one cycle, in the cycle after acceptance, with that slot number on alloc_slot.
- R3: While all NUM_REGS slots are occupied, iss_ready is 0 for a load or a move-in.
- R4: A load sends VLEN read requests (mem_req_we 0) to addresses iss_addr, iss_addr+1, ... in ascending order. The in-order responses fill element 0, 1, ... of the slot.
- R5: A move-out (iss_op 2) of the slot named on iss_slot sends its VLEN elements on xout, element 0 first. Element i is not offered before the memory response for element i has arrived.
- R6: A move-out releases its slot once its last element is accepted, so the next allocation may return that slot.
- R7: A move-in accepts VLEN elements on xin and writes them into the slot in arrival order, element 0 first.
- R8: A store (iss_op 3) writes element i of the named slot to address iss_addr+i with mem_req_we 1. The slot stays allocated and its contents are unchanged.
- R9: A store-and-free (iss_op 4) writes like a store and releases the slot once its last write is accepted.
- R10: On mem_req and xout, a raised valid stays high with a stable payload until ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Micro-operation offered |
| iss_ready | output | 1 | Micro-operation accepted this cycle when valid |
| iss_op | input | 3 | 0 load, 1 move-in, 2 move-out, 3 store, 4 store-and-free |
| iss_slot | input | $clog2(NUM_REGS) | Slot named by move-out and store operations |
| iss_addr | input | AW | Base element address for load and store operations |
| alloc_valid | output | 1 | One-cycle pulse reporting a new allocation |
| alloc_slot | output | $clog2(NUM_REGS) | Slot number just allocated |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Element address |
| mem_req_wdata | output | DW | Write element |
| mem_rsp_valid | input | 1 | Read element returned |
| mem_rsp_data | input | DW | Returned element |
| xin_valid | input | 1 | Interconnect element offered for a move-in |
| xin_ready | output | 1 | Move-in element accepted |
| xin_data | input | DW | Move-in element |
| xout_valid | output | 1 | Move-out element offered |
| xout_ready | input | 1 | Interconnect accepts the element |
| xout_data | output | DW | Move-out element |

## Verification
The assertions assume that memory responses arrive only while a load has elements outstanding, and in request order. They also assume that move-out and store operations name slots that are currently allocated, that iss_op stays within the five defined codes, and that xin holds its element until accepted. The bench keeps to these rules. Its memory responder answers only reads it has queued, in order, with a latency that varies but never reorders. The bench names only slots it has been given on alloc_slot and not yet released, and it holds xin data until it sees xin_ready. Back-pressure on the memory request and transfer output channels comes from several ready patterns, so the hold rules of R10 are tested while data moves.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [2:0] {
    OP_LOAD       = 3'd0,
    OP_MOVE_IN    = 3'd1,
    OP_MOVE_OUT   = 3'd2,
    OP_STORE      = 3'd3,
    OP_STORE_FREE = 3'd4
  } mcr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LDREQ = 3'd1,
    ST_MVIN  = 3'd2,
    ST_MVOUT = 3'd3,
    ST_STORE = 3'd4
  } mcr_state_e;

endpackage

// File: rtl/mcr_slot_pool.sv
module mcr_slot_pool #(
  parameter int NUM_REGS = 4,
  parameter int SW       = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  input  logic                free_en,
  input  logic [SW-1:0]       free_slot,
  output logic                any_free,
  output logic [SW-1:0]       pick_slot,
  output logic [NUM_REGS-1:0] busy_mask
);

  logic [NUM_REGS-1:0] busy_q;
  logic                found;

  assign busy_mask = busy_q;
  assign any_free  = ~&busy_q;

  // lowest-numbered free slot wins
  always_comb begin
    pick_slot = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!busy_q[i] && !found) begin
        pick_slot = SW'(i);
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      if (alloc_en) busy_q[pick_slot] <= 1'b1;
      if (free_en)  busy_q[free_slot] <= 1'b0;
    end
  end

endmodule

// File: rtl/mcr_load_tracker.sv
module mcr_load_tracker #(
  parameter int NUM_REGS = 4,
  parameter int VLEN     = 4,
  parameter int SW       = $clog2(NUM_REGS),
  parameter int CW       = $clog2(VLEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [SW-1:0] push_slot,
  input  logic          rsp_valid,
  output logic [SW-1:0] head_slot,
  output logic [CW-1:0] head_elem,
  output logic          empty
);

  logic [SW-1:0] order_q [NUM_REGS];
  logic [SW-1:0] wr_ptr, rd_ptr;
  logic [SW:0]   count;
  logic [CW-1:0] elem_q;
  logic          elem_last;
  logic          pop;

  function automatic logic [SW-1:0] ptr_next(input logic [SW-1:0] p);
    return (p == SW'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign elem_last = (elem_q == CW'(VLEN - 1));
  assign pop       = rsp_valid && elem_last;
  assign head_slot = order_q[rd_ptr];
  assign head_elem = elem_q;
  assign empty     = (count == '0);

  always_ff @(posedge clk) begin
    if (push_en) order_q[wr_ptr] <= push_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      elem_q <= '0;
    end else begin
      if (push_en) wr_ptr <= ptr_next(wr_ptr);
      if (rsp_valid) elem_q <= elem_last ? '0 : elem_q + 1'b1;
      if (pop) rd_ptr <= ptr_next(rd_ptr);
      case ({push_en, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/mcr_slot_store.sv
module mcr_slot_store #(
  parameter int NUM_REGS = 4,
  parameter int VLEN     = 4,
  parameter int DW       = 16,
  parameter int SW       = $clog2(NUM_REGS),
  parameter int CW       = $clog2(VLEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_en,
  input  logic [SW-1:0] clear_slot,
  input  logic          wa_en,
  input  logic [SW-1:0] wa_slot,
  input  logic [CW-1:0] wa_elem,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [SW-1:0] wb_slot,
  input  logic [CW-1:0] wb_elem,
  input  logic [DW-1:0] wb_data,
  input  logic [SW-1:0] rd_slot,
  input  logic [CW-1:0] rd_elem,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);

  logic [VLEN-1:0][DW-1:0] rows     [NUM_REGS];
  logic [VLEN-1:0]         vld_rows [NUM_REGS];

  for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
    logic [VLEN-1:0][DW-1:0] row_q;
    logic [VLEN-1:0]         vld_q;
    logic                    hit_a, hit_b, hit_clr;

    assign hit_a   = wa_en    && (wa_slot    == SW'(s));
    assign hit_b   = wb_en    && (wb_slot    == SW'(s));
    assign hit_clr = clear_en && (clear_slot == SW'(s));

    always_ff @(posedge clk) begin
      if (hit_a) row_q[wa_elem] <= wa_data;
      if (hit_b) row_q[wb_elem] <= wb_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else begin
        if (hit_clr) vld_q <= '0;
        if (hit_a)   vld_q[wa_elem] <= 1'b1;
        if (hit_b)   vld_q[wb_elem] <= 1'b1;
      end
    end

    assign rows[s]     = row_q;
    assign vld_rows[s] = vld_q;
  end

  assign rd_data = rows[rd_slot][rd_elem];
  assign rd_vld  = vld_rows[rd_slot][rd_elem];

endmodule

// File: rtl/mcr_decouple_mgr.sv
module mcr_decouple_mgr
  import mcr_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int VLEN     = 4,
  parameter int DW       = 16,
  parameter int AW       = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iss_valid,
  output logic                        iss_ready,
  input  logic [2:0]                  iss_op,
  input  logic [$clog2(NUM_REGS)-1:0] iss_slot,
  input  logic [AW-1:0]               iss_addr,
  output logic                        alloc_valid,
  output logic [$clog2(NUM_REGS)-1:0] alloc_slot,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic                        mem_req_we,
  output logic [AW-1:0]               mem_req_addr,
  output logic [DW-1:0]               mem_req_wdata,
  input  logic                        mem_rsp_valid,
  input  logic [DW-1:0]               mem_rsp_data,
  input  logic                        xin_valid,
  output logic                        xin_ready,
  input  logic [DW-1:0]               xin_data,
  output logic                        xout_valid,
  input  logic                        xout_ready,
  output logic [DW-1:0]               xout_data
);

  localparam int SW = $clog2(NUM_REGS);
  localparam int CW = $clog2(VLEN);

  mcr_state_e    state;
  mcr_op_e       op_in;
  logic [SW-1:0] cur_slot;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cnt;
  logic          free_after;
  logic          last;
  logic          needs_alloc;
  logic          accept;
  logic          alloc_en;
  logic          step;
  logic          free_en;
  logic          any_free;
  logic [SW-1:0] pick_slot;
  logic [NUM_REGS-1:0] busy_mask;
  logic [SW-1:0] head_slot;
  logic [CW-1:0] head_elem;
  logic          trk_empty;
  logic [DW-1:0] rd_data;
  logic          rd_vld;
  logic          xin_fire;

  assign op_in       = mcr_op_e'(iss_op);
  assign last        = (cnt == CW'(VLEN - 1));
  assign needs_alloc = (op_in == OP_LOAD) || (op_in == OP_MOVE_IN);
  assign iss_ready   = (state == ST_IDLE) && (!needs_alloc || any_free);
  assign accept      = iss_valid && iss_ready;
  assign alloc_en    = accept && needs_alloc;

  // stream outputs, all driven from the current slot and element
  assign xin_ready     = (state == ST_MVIN);
  assign xin_fire      = xin_ready && xin_valid;
  assign mem_req_valid = (state == ST_LDREQ) || ((state == ST_STORE) && rd_vld);
  assign mem_req_we    = (state == ST_STORE);
  assign mem_req_addr  = cur_addr + AW'(cnt);
  assign mem_req_wdata = rd_data;
  assign xout_valid    = (state == ST_MVOUT) && rd_vld;
  assign xout_data     = rd_data;

  always_comb begin
    case (state)
      ST_LDREQ, ST_STORE: step = mem_req_valid && mem_req_ready;
      ST_MVIN:            step = xin_fire;
      ST_MVOUT:           step = xout_valid && xout_ready;
      default:            step = 1'b0;
    endcase
  end

  assign free_en = step && last &&
                   ((state == ST_MVOUT) || ((state == ST_STORE) && free_after));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_slot    <= '0;
      cur_addr    <= '0;
      cnt         <= '0;
      free_after  <= 1'b0;
      alloc_valid <= 1'b0;
      alloc_slot  <= '0;
    end else begin
      alloc_valid <= alloc_en;
      if (alloc_en) alloc_slot <= pick_slot;
      if (state == ST_IDLE) begin
        if (accept) begin
          cnt        <= '0;
          cur_addr   <= iss_addr;
          free_after <= (op_in == OP_STORE_FREE);
          cur_slot   <= needs_alloc ? pick_slot : iss_slot;
          case (op_in)
            OP_LOAD:       state <= ST_LDREQ;
            OP_MOVE_IN:    state <= ST_MVIN;
            OP_MOVE_OUT:   state <= ST_MVOUT;
            OP_STORE:      state <= ST_STORE;
            OP_STORE_FREE: state <= ST_STORE;
            default:       state <= ST_IDLE;
          endcase
        end
      end else if (step) begin
        cnt <= last ? '0 : cnt + 1'b1;
        if (last) state <= ST_IDLE;
      end
    end
  end

  mcr_slot_pool #(
    .NUM_REGS (NUM_REGS),
    .SW       (SW)
  ) i_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .free_en   (free_en),
    .free_slot (cur_slot),
    .any_free  (any_free),
    .pick_slot (pick_slot),
    .busy_mask (busy_mask)
  );

  mcr_load_tracker #(
    .NUM_REGS (NUM_REGS),
    .VLEN     (VLEN),
    .SW       (SW),
    .CW       (CW)
  ) i_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (accept && (op_in == OP_LOAD)),
    .push_slot (pick_slot),
    .rsp_valid (mem_rsp_valid),
    .head_slot (head_slot),
    .head_elem (head_elem),
    .empty     (trk_empty)
  );

  mcr_slot_store #(
    .NUM_REGS (NUM_REGS),
    .VLEN     (VLEN),
    .DW       (DW),
    .SW       (SW),
    .CW       (CW)
  ) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_en   (alloc_en),
    .clear_slot (pick_slot),
    .wa_en      (xin_fire),
    .wa_slot    (cur_slot),
    .wa_elem    (cnt),
    .wa_data    (xin_data),
    .wb_en      (mem_rsp_valid),
    .wb_slot    (head_slot),
    .wb_elem    (head_elem),
    .wb_data    (mem_rsp_data),
    .rd_slot    (cur_slot),
    .rd_elem    (cnt),
    .rd_data    (rd_data),
    .rd_vld     (rd_vld)
  );

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
  parameter int NUM_REGS = 4,
  parameter int VLEN     = 4,
  parameter int DW       = 16,
  parameter int AW       = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        iss_valid,
  input logic                        iss_ready,
  input logic [2:0]                  iss_op,
  input logic                        alloc_valid,
  input logic [$clog2(NUM_REGS)-1:0] alloc_slot,
  input logic [NUM_REGS-1:0]         busy_mask,
  input logic                        free_en,
  input logic [$clog2(NUM_REGS)-1:0] free_slot,
  input logic                        mem_req_valid,
  input logic                        mem_req_ready,
  input logic                        mem_req_we,
  input logic [AW-1:0]               mem_req_addr,
  input logic [DW-1:0]               mem_req_wdata,
  input logic                        mem_rsp_valid,
  input logic                        trk_empty,
  input logic                        xout_valid,
  input logic                        xout_ready,
  input logic [DW-1:0]               xout_data
);

  logic [NUM_REGS-1:0] busy_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_prev <= '0;
    else        busy_prev <= busy_mask;
  end

  // R2: the reported slot was free before the allocation and is occupied after it
  p_alloc_from_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (!busy_prev[alloc_slot] && busy_mask[alloc_slot]));

  // R3: no allocating operation is accepted while the pool is full
  p_stall_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_op <= 3'd1) && (&busy_mask)) |-> !iss_ready);

  // R4: responses only arrive while a load has elements outstanding
  p_rsp_has_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !trk_empty);

  // R6: only an occupied slot is released
  p_free_occupied_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> busy_mask[free_slot]);

  // R10: memory request holds until accepted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  // R10: transfer output holds until accepted
  p_xout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xout_valid && !xout_ready) |=> (xout_valid && $stable(xout_data)));

endmodule

bind mcr_decouple_mgr mcr_checker #(
  .NUM_REGS (NUM_REGS),
  .VLEN     (VLEN),
  .DW       (DW),
  .AW       (AW)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .iss_valid     (iss_valid),
  .iss_ready     (iss_ready),
  .iss_op        (iss_op),
  .alloc_valid   (alloc_valid),
  .alloc_slot    (alloc_slot),
  .busy_mask     (busy_mask),
  .free_en       (free_en),
  .free_slot     (cur_slot),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .trk_empty     (trk_empty),
  .xout_valid    (xout_valid),
  .xout_ready    (xout_ready),
  .xout_data     (xout_data)
);

// File: tb/test_mcr_decouple_mgr.sv
module test_mcr_decouple_mgr;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int VL = 4;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic          iss_ready;
  logic [2:0]    iss_op = '0;
  logic [1:0]    iss_slot = '0;
  logic [AW-1:0] iss_addr = '0;
  logic          alloc_valid;
  logic [1:0]    alloc_slot;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic          mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic          xin_valid = 1'b0;
  logic          xin_ready;
  logic [DW-1:0] xin_data = '0;
  logic          xout_valid;
  logic          xout_ready;
  logic [DW-1:0] xout_data;

  mcr_decouple_mgr #(.NUM_REGS(NR), .VLEN(VL), .DW(DW), .AW(AW)) i_mcr_decouple_mgr (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_slot(iss_slot), .iss_addr(iss_addr),
    .alloc_valid(alloc_valid), .alloc_slot(alloc_slot),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xin_valid(xin_valid), .xin_ready(xin_ready), .xin_data(xin_data),
    .xout_valid(xout_valid), .xout_ready(xout_ready), .xout_data(xout_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int lat_mode = 0;
  int rdy_mode = 0;
  logic [DW-1:0] mem [256];
  int rq_addr [256];
  int rq_due [256];
  int rq_h = 0, rq_t = 0, last_due = 0, nreq = 0, rsp_total = 0;
  logic [DW-1:0] out_d [1024];
  int out_rsp [1024];
  int out_n = 0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 37 + 5);
  endfunction

  initial forever #(CLK_PERIOD / 2) clk = ~clk;
  initial forever begin @(posedge clk); cyc = cyc + 1; end

  // memory responder and transfer-output sink
  initial begin
    int lat, due;
    for (int a = 0; a < 256; a++) mem[a] = pat(a);
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; xout_ready = 1'b0;
    forever begin
      @(negedge clk); #1;
      case (rdy_mode)
        0: begin mem_req_ready = 1'b1; xout_ready = 1'b1; end
        1: begin mem_req_ready = (cyc % 3) != 0; xout_ready = (cyc % 4) != 1; end
        default: begin mem_req_ready = (cyc % 5) < 2; xout_ready = (cyc % 3) == 0; end
      endcase
      if (rq_h != rq_t && cyc >= rq_due[rq_h % 256]) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mem[rq_addr[rq_h % 256]];
      end else begin
        mem_rsp_valid = 1'b0;
      end
      #1;
      if (xout_valid && xout_ready) begin
        out_d[out_n % 1024] = xout_data; out_rsp[out_n % 1024] = rsp_total; out_n++;
      end
      if (mem_rsp_valid) begin rq_h++; rsp_total++; end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
        else begin
          case (lat_mode)
            0: lat = 1;
            1: lat = 1 + (nreq % 3);
            2: lat = 2 + ((nreq * 5) % 7);
            default: lat = 9;
          endcase
          due = cyc + lat;
          if (due <= last_due) due = last_due + 1;
          rq_addr[rq_t % 256] = mem_req_addr; rq_due[rq_t % 256] = due;
          rq_t++; last_due = due; nreq++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int op, input int slot, input int addr, output int gs, output bit gv);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 3'(op); iss_slot = 2'(slot); iss_addr = AW'(addr);
    #3;
    while (!iss_ready) begin @(negedge clk); #3; end
    @(posedge clk); #1;
    iss_valid = 1'b0;
    @(negedge clk); #3;
    gv = alloc_valid; gs = int'(alloc_slot);
  endtask

  task automatic feed(input int base);
    for (int i = 0; i < VL; i++) begin
      @(negedge clk);
      xin_valid = 1'b1; xin_data = DW'(base + i);
      #3;
      while (!xin_ready) begin @(negedge clk); #3; end
      @(posedge clk); #1;
      xin_valid = 1'b0;
    end
  endtask

  task automatic wait_out(input int n);
    int t = 0;
    while (out_n < n && t < 3000) begin @(negedge clk); t++; end
    #3;
  endtask

  task automatic drain_check(input int slot, input int exp_base, input bit use_pat, input string tag);
    int gs, ob; bit gv;
    logic [DW-1:0] e;
    ob = out_n;
    issue(2, slot, 0, gs, gv);
    wait_out(ob + VL);
    for (int i = 0; i < VL; i++) begin
      e = use_pat ? pat(exp_base + i) : DW'(exp_base + i);
      chk(out_d[(ob + i) % 1024] == e, tag, int'(out_d[(ob + i) % 1024]), int'(e));
    end
  endtask

  initial begin
    int gs, fs, base0, ob; bit gv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R1 reset state
    chk(iss_ready == 1'b1, "R1 iss_ready", int'(iss_ready), 1);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", int'(mem_req_valid), 0);
    chk(xout_valid == 1'b0, "R1 xout_valid", int'(xout_valid), 0);
    chk(xin_ready == 1'b0, "R1 xin_ready", int'(xin_ready), 0);
    chk(alloc_valid == 1'b0, "R1 alloc_valid", int'(alloc_valid), 0);

    // sweep over latency and back-pressure patterns
    for (int cfg = 0; cfg < 9; cfg++) begin
      lat_mode = cfg / 3; rdy_mode = cfg % 3;
      for (int k = 0; k < NR; k++) begin
        issue(0, 0, cfg * 16 + k * 4, gs, gv);
        chk(gv && gs == k, "R2 load allocation", gs, k);
      end
      repeat (30) @(negedge clk);
      @(negedge clk);
      iss_valid = 1'b1; iss_op = 3'd0; iss_addr = '0;
      #3;
      chk(iss_ready == 1'b0, "R3 stall on full pool", int'(iss_ready), 0);
      iss_valid = 1'b0;
      fs = cfg % NR;
      drain_check(fs, cfg * 16 + fs * 4, 1'b1, "R4 R5 R10 move-out data");
      issue(0, 0, cfg * 16 + fs * 4, gs, gv);
      chk(gv && gs == fs, "R6 freed slot reused", gs, fs);
      for (int k = 0; k < NR; k++)
        drain_check(k, cfg * 16 + k * 4, 1'b1, "R4 R5 R10 ordered drain");
    end

    // R5 element-wise wait behind a slow load
    lat_mode = 3; rdy_mode = 0;
    base0 = rsp_total;
    issue(0, 0, 60, gs, gv);
    chk(gv && gs == 0, "R2 allocation on empty pool", gs, 0);
    ob = out_n;
    drain_check(0, 60, 1'b1, "R5 slow load data");
    for (int i = 0; i < VL; i++)
      chk(out_rsp[(ob + i) % 1024] - base0 > i, "R5 element not before its response",
          out_rsp[(ob + i) % 1024] - base0, i + 1);

    // move-in, plain store, store-and-free
    lat_mode = 1; rdy_mode = 1;
    issue(1, 0, 0, gs, gv);
    chk(gv && gs == 0, "R2 move-in allocation", gs, 0);
    feed(16'h1000);
    issue(3, 0, 200, gs, gv);
    repeat (20) @(negedge clk);
    for (int i = 0; i < VL; i++)
      chk(mem[200 + i] == DW'(16'h1000 + i), "R7 R8 store write", int'(mem[200 + i]), 16'h1000 + i);
    issue(0, 0, 8, gs, gv);
    chk(gv && gs == 1, "R8 slot kept after store", gs, 1);
    drain_check(0, 16'h1000, 1'b0, "R8 contents intact after store");
    drain_check(1, 8, 1'b1, "R4 load after store");
    issue(1, 0, 0, gs, gv);
    chk(gv && gs == 0, "R2 move-in reuse", gs, 0);
    feed(16'h2000);
    issue(4, 0, 220, gs, gv);
    repeat (20) @(negedge clk);
    for (int i = 0; i < VL; i++)
      chk(mem[220 + i] == DW'(16'h2000 + i), "R9 store-and-free write", int'(mem[220 + i]), 16'h2000 + i);
    issue(1, 0, 0, gs, gv);
    chk(gv && gs == 0, "R9 slot released", gs, 0);
    feed(16'h3000);
    drain_check(0, 16'h3000, 1'b0, "R7 move-in order");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule